// File: doc/BRIEF.md
# Double-Buffered 10-Bit PWM Generator

This block drives one pulse-width-modulated output from an 8-bit period timer. The timer advances once every four input clocks times a selectable prescale factor of 1, 4 or 16. Two sub-count bits extend the timer into a 10-bit time base. At 1:1 these bits come from a free-running phase counter; at the other ratios they are the two upper bits of the prescaler. As a result, the duty resolution is always one prescale step of input clocks.

The host presents an 8-bit period value and a 10-bit duty value. The duty value is split into an upper byte and a lower 2-bit field, and both may change at any moment. The duty value is copied into a shadow latch only when the timer wraps at the end of a period, or when the block is enabled. This means a period already in progress always finishes with the duty it started with. The output rises at the start of each period, unless the shadow duty is zero. It falls when the time base reaches the shadow duty. A read-only copy of the shadow latch is brought out so the host can see which duty is currently in force.

Top module: `pwm10_gen`

## Requirements
- R1: With period value PR and prescale P, consecutive rising edges of `pwm_o` are (PR+1)·4·P input clocks apart.
- R2: `presc_sel_i` selects the prescale factor as follows: 2'b00 selects 1, 2'b01 selects 4, and 2'b10 or 2'b11 selects 16.
- R3: For a shadow duty D with 0 < D < 4·(PR+1), `pwm_o` stays high for exactly D·P input clocks in each period.
- R4: The duty value is {`duty_hi_i`, `duty_lo_i`}, where `duty_lo_i` holds bits 1:0. A change in `duty_lo_i` alone changes the high time by P clocks per count at every prescale.
- R5: When the shadow duty is zero, `pwm_o` stays low for the whole period.
- R6: When the shadow duty is 4·(PR+1) or more, `pwm_o` stays high across every cycle of the period.
- R7: `shadow_duty_o` changes only at a period wrap or on the cycle the block is enabled. When it changes, it takes the duty value presented in that cycle. A duty change made mid-period therefore shapes only the next period.
- R8: While `en_i` is low, `pwm_o` is low and `shadow_duty_o` holds its value. On the first clock with `en_i` high, the shadow loads the duty value and a new period begins, so that `pwm_o` is high in the following cycle if the duty is nonzero.
- R9: After reset, `pwm_o` is 0 and `shadow_duty_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; low holds the timers cleared and the output low |
| period_i | input | 8 | Period value PR |
| duty_hi_i | input | 8 | Duty bits 9:2 |
| duty_lo_i | input | 2 | Duty bits 1:0 |
| presc_sel_i | input | 2 | Prescale select (00: 1, 01: 4, 1x: 16) |
| pwm_o | output | 1 | PWM output |
| shadow_duty_o | output | 10 | Duty value currently in force |

## Verification
Faults in the time base show up at the ports as a pulse spacing or pulse width that is off by a multiple of the prescale. This is visible within one period after the block is enabled. A shadow latch that loads at the wrong moment shows up when a duty value is written mid-period: `shadow_duty_o` changes before the wrap, or the current pulse takes the new width. Both are seen within that same period. A fault in the zero-duty or full-duty handling appears as a single stray edge of `pwm_o` at the period boundary.

// File: rtl/pwm10_pkg.sv
package pwm10_pkg;

  localparam int FINE_W     = 2;
  localparam int PS_SHIFT_W = 4;
  localparam int SUB_W      = FINE_W + PS_SHIFT_W;

  typedef enum logic [1:0] {
    PS_DIV1  = 2'b00,
    PS_DIV4  = 2'b01,
    PS_DIV16 = 2'b10
  } presc_e;

  function automatic int presc_shift(input logic [1:0] sel);
    if (sel[1])       return 4;
    else if (sel[0])  return 2;
    else              return 0;
  endfunction

  function automatic logic [SUB_W-1:0] sub_limit(input logic [1:0] sel);
    int span;
    span = (1 << (FINE_W + presc_shift(sel))) - 1;
    return SUB_W'(span);
  endfunction

  function automatic logic [FINE_W-1:0] fine_bits(input logic [SUB_W-1:0] sub,
                                                  input logic [1:0]       sel);
    return FINE_W'(sub >> presc_shift(sel));
  endfunction

endpackage

// File: rtl/pwm10_timebase.sv
module pwm10_timebase
  import pwm10_pkg::*;
#(
  parameter int TMR_W = 8,
  localparam int TB_W = TMR_W + FINE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [TMR_W-1:0] period_i,
  input  logic [1:0]       sel_i,
  output logic [TB_W-1:0]  tb_cur_o,
  output logic [TB_W-1:0]  tb_nxt_o,
  output logic             wrap_o
);

  logic [SUB_W-1:0] sub_q, sub_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             sub_last, tmr_last, wrap;
  logic             cnt_en;

  always_comb begin
    sub_last = (sub_q >= sub_limit(sel_i));
    tmr_last = (tmr_q == period_i);
    wrap     = run_i && sub_last && tmr_last;
    cnt_en   = clr_i || run_i;
    sub_d    = sub_q;
    tmr_d    = tmr_q;
    if (clr_i) begin
      sub_d = '0;
      tmr_d = '0;
    end else if (run_i) begin
      sub_d = sub_last ? '0 : sub_q + 1'b1;
      if (wrap)
        tmr_d = '0;
      else if (sub_last)
        tmr_d = tmr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q <= '0;
      tmr_q <= '0;
    end else if (cnt_en) begin
      sub_q <= sub_d;
      tmr_q <= tmr_d;
    end
  end

  assign tb_cur_o = {tmr_q, fine_bits(sub_q, sel_i)};
  assign tb_nxt_o = {tmr_d, fine_bits(sub_d, sel_i)};
  assign wrap_o   = wrap;

endmodule

// File: rtl/pwm10_shadow.sv
module pwm10_shadow #(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [DW-1:0] duty_i,
  output logic [DW-1:0] shadow_o
);

  logic [DW-1:0] shadow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      shadow_q <= '0;
    else if (load_i)
      shadow_q <= duty_i;
  end

  assign shadow_o = shadow_q;

endmodule

// File: rtl/pwm10_outstage.sv
module pwm10_outstage #(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          set_evt_i,
  input  logic [DW-1:0] duty_in_i,
  input  logic [DW-1:0] shadow_i,
  input  logic [DW-1:0] tb_nxt_i,
  output logic          pwm_o
);

  logic pwm_q, pwm_d;

  always_comb begin
    pwm_d = pwm_q;
    if (!en_i)
      pwm_d = 1'b0;
    else if (set_evt_i)
      pwm_d = (duty_in_i != '0);
    else if (tb_nxt_i == shadow_i)
      pwm_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pwm_q <= 1'b0;
    else
      pwm_q <= pwm_d;
  end

  assign pwm_o = pwm_q;

endmodule

// File: rtl/pwm10_gen.sv
module pwm10_gen
  import pwm10_pkg::*;
#(
  parameter int TMR_W = 8,
  localparam int DUTY_W = TMR_W + FINE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [TMR_W-1:0]  period_i,
  input  logic [TMR_W-1:0]  duty_hi_i,
  input  logic [FINE_W-1:0] duty_lo_i,
  input  logic [1:0]        presc_sel_i,
  output logic              pwm_o,
  output logic [DUTY_W-1:0] shadow_duty_o
);

  logic              en_q;
  logic              start, run, wrap, load;
  logic [DUTY_W-1:0] duty_in, tb_cur, tb_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      en_q <= 1'b0;
    else
      en_q <= en_i;
  end

  assign start   = en_i && !en_q;
  assign run     = en_i && en_q;
  assign load    = wrap || start;
  assign duty_in = {duty_hi_i, duty_lo_i};

  pwm10_timebase #(.TMR_W(TMR_W)) u_tb (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (!en_i),
    .run_i    (run),
    .period_i (period_i),
    .sel_i    (presc_sel_i),
    .tb_cur_o (tb_cur),
    .tb_nxt_o (tb_nxt),
    .wrap_o   (wrap)
  );

  pwm10_shadow #(.DW(DUTY_W)) u_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .duty_i   (duty_in),
    .shadow_o (shadow_duty_o)
  );

  pwm10_outstage #(.DW(DUTY_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (en_i),
    .set_evt_i (load),
    .duty_in_i (duty_in),
    .shadow_i  (shadow_duty_o),
    .tb_nxt_i  (tb_nxt),
    .pwm_o     (pwm_o)
  );

endmodule

// File: rtl/pwm10_gen_chk.sv
module pwm10_gen_chk #(
  parameter int DW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          wrap,
  input logic          start,
  input logic [DW-1:0] duty_in,
  input logic [DW-1:0] tb_cur,
  input logic          pwm,
  input logic [DW-1:0] shadow
);

  assert_off_when_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pwm);

  assert_shadow_only_at_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wrap || start) |=> $stable(shadow));

  assert_shadow_takes_duty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap || start) |=> shadow == $past(duty_in));

  assert_zero_duty_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wrap && !start && shadow == '0) |=> !pwm);

  assert_set_at_period_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && duty_in != '0) |=> (pwm && tb_cur == '0));

endmodule

bind pwm10_gen pwm10_gen_chk #(.DW(DUTY_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en      (en_i),
  .wrap    (wrap),
  .start   (start),
  .duty_in (duty_in),
  .tb_cur  (tb_cur),
  .pwm     (pwm_o),
  .shadow  (shadow_duty_o)
);

// File: tb/pwm10_gen_tb.sv
`timescale 1ns/1ps
module pwm10_gen_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic [7:0] period;
  logic [7:0] dhi;
  logic [1:0] dlo;
  logic [1:0] psel;
  logic       pwm;
  logic [9:0] shadow;

  int n_checks = 0;
  int n_errors = 0;

  always #2.5 clk = ~clk;

  pwm10_gen u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .en_i          (en),
    .period_i      (period),
    .duty_hi_i     (dhi),
    .duty_lo_i     (dlo),
    .presc_sel_i   (psel),
    .pwm_o         (pwm),
    .shadow_duty_o (shadow)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic restart(input int pr, input int d, input logic [1:0] sel);
    @(negedge clk);
    en = 1'b0;
    period = 8'(pr);
    dhi = 8'(d >> 2);
    dlo = 2'(d);
    psel = sel;
    repeat (2) @(negedge clk);
    en = 1'b1;
  endtask

  // skips the current pulse, then measures one full high and one full period
  task automatic meas(output int hi, output int per);
    int guard;
    guard = 0;
    while (pwm && guard < 5000) begin @(negedge clk); guard++; end
    while (!pwm && guard < 5000) begin @(negedge clk); guard++; end
    hi = 0;
    while (pwm && hi < 5000) begin hi++; @(negedge clk); end
    per = hi;
    while (!pwm && per < 5000) begin per++; @(negedge clk); end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(pwm == 1'b0, "R9 pwm after reset", int'(pwm), 0);
    chk(shadow == 10'd0, "R9 shadow after reset", int'(shadow), 0);
  endtask

  task automatic t_pulse(input int pr, input int d, input logic [1:0] sel,
                         input int p, input string req);
    int hi, per;
    restart(pr, d, sel);
    meas(hi, per);
    chk(per == (pr + 1) * 4 * p, {req, " R1 period"}, per, (pr + 1) * 4 * p);
    chk(hi == d * p, {req, " R3 high time"}, hi, d * p);
  endtask

  task automatic t_zero();
    int highs;
    restart(9, 0, 2'b00);
    highs = 0;
    repeat (100) begin @(negedge clk); if (pwm) highs++; end
    chk(highs == 0, "R5 zero duty stays low", highs, 0);
  endtask

  task automatic t_full(input int d);
    int lows;
    restart(3, d, 2'b00);
    @(negedge clk);
    lows = 0;
    repeat (64) begin @(negedge clk); if (!pwm) lows++; end
    chk(lows == 0, "R6 full duty stays high", lows, 0);
  endtask

  task automatic t_midwrite();
    int hi, per, guard;
    restart(9, 10, 2'b00);
    guard = 0;
    while (pwm && guard < 500) begin @(negedge clk); guard++; end
    while (!pwm && guard < 500) begin @(negedge clk); guard++; end
    hi = 0;
    while (pwm && hi < 500) begin
      hi++;
      if (hi == 3) begin dhi = 8'(25 >> 2); dlo = 2'(25); end
      @(negedge clk);
    end
    chk(hi == 10, "R7 current pulse keeps old duty", hi, 10);
    chk(shadow == 10'd10, "R7 shadow holds until wrap", int'(shadow), 10);
    meas(hi, per);
    chk(hi == 25, "R7 next pulse uses new duty", hi, 25);
    chk(shadow == 10'd25, "R7 shadow updated at wrap", int'(shadow), 25);
  endtask

  task automatic t_enable();
    logic [9:0] held;
    int highs;
    @(negedge clk);
    en = 1'b0;
    held = shadow;
    period = 8'd9; psel = 2'b00; dhi = 8'd1; dlo = 2'd3;
    highs = 0;
    repeat (6) begin @(negedge clk); if (pwm) highs++; end
    chk(highs == 0, "R8 output low while disabled", highs, 0);
    chk(shadow == held, "R8 shadow held while disabled", int'(shadow), int'(held));
    en = 1'b1;
    @(negedge clk);
    chk(shadow == 10'd7, "R8 shadow loads on enable", int'(shadow), 7);
    chk(pwm == 1'b1, "R8 output high in first cycle", int'(pwm), 1);
    highs = 1;
    @(negedge clk);
    while (pwm && highs < 500) begin highs++; @(negedge clk); end
    chk(highs == 7, "R8 first pulse width", highs, 7);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 100000, 0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    en = 1'b0;
    period = 8'd0; dhi = 8'd0; dlo = 2'd0; psel = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_pulse(9, 13, 2'b00, 1, "R2 div1");
    t_pulse(20, 37, 2'b01, 4, "R2 div4");
    t_pulse(4, 19, 2'b11, 16, "R2 R4 div16 sel11");
    t_pulse(4, 19, 2'b10, 16, "R2 div16 sel10");
    t_pulse(20, 38, 2'b01, 4, "R4 low bits div4");
    t_zero();
    t_full(16);
    t_full(40);
    t_midwrite();
    t_enable();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule